// File: doc/BRIEF.md
# Serial Module-Type Announcer for Backplane Slots

Each plug-in module on the backplane carries one copy of this block. During system initialization it tells a console which kind of module sits in which slot. All modules share a single open-drain identification wire. The console toggles an identification clock, and every module counts the rising edges of that clock from the moment system reset is released. A module talks only inside its own eight-edge window, so the modules never collide on the wire.

The window of a module opens after eight times its backplane-wired slot number of identification-clock rising edges. Inside the window the module shifts out its 8-bit type code, most significant bit first, one bit per identification-clock period. A 0 bit pulls the wire low. A 1 bit leaves the wire released. The console samples the wire before each rising edge it generates. The identification clock comes from outside the system clock domain, so the block passes it through a synchronizer and counts its rising edges in the system clock domain. The count saturates, so once the window is over the module stays silent until the next reset.

Top module: `slot_type_announcer`

## Requirements
- R1: While `rst_n` is low, `id_pull` is 0, so the wire is released.
- R2: Only a low-to-high transition of `id_clk` seen after reset release advances the schedule. A level held high through reset release is not counted, and falling transitions are never counted.
- R3: With slot number S (S < 14), the window holds the counts 8*S to 8*S+7, where the count is the number of counted rising edges. For every count before 8*S, `id_pull` is 0.
- R4: At count 8*S+k (k = 0..7), the block sends type-code bit 7-k, so the code goes out most significant bit first. `id_pull` is 1 when that bit is 0 and 0 when that bit is 1.
- R5: From count 8*S+8 onward `id_pull` stays 0, however many further edges arrive, until the next reset. The internal count saturates and never wraps.
- R6: The block captures `slot_id` and `type_code` while reset is asserted. Changes on those inputs after reset release have no effect until the next reset.
- R7: A slot number of 14 or more never drives the wire.
- R8: Asserting reset in the middle of a window releases the wire and restarts the schedule from count 0 with the newly captured slot and code.
- R9: After `id_clk` rises, `id_pull` takes its new value on the fourth rising edge of `clk`. It still shows the old value after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, synchronous, active low |
| id_clk | input | 1 | Identification clock toggled by the console, asynchronous to `clk` |
| slot_id | input | 4 | Backplane-wired slot number |
| type_code | input | 8 | The module's type code |
| id_pull | output | 1 | 1 = sink the shared identification wire low |

## Verification
The hardest state to reach from the ports is the tail of the schedule. Here the count has saturated, the module's window is long past, and further console edges must not revive the wire. The bench puts a module in the last slot and sends hundreds of extra identification-clock periods beyond the final window. It also does the same with out-of-range slot numbers. A second awkward case is an identification clock already high when reset is released. The bench holds it high across release, lowers it, and only then raises it, reading the count back through which type-code bit appears on the wire.

// File: rtl/slot_id_pkg.sv
`timescale 1ns/1ps
// Shared sizing constants for the slot-scheduled type announcer.
// Assumes a type code of a power-of-two width so bit selection is exact.
package slot_id_pkg;
    localparam int ID_CODE_W      = 8;   // bits per type code and per window
    localparam int ID_SLOT_W      = 4;   // width of the wired slot number
    localparam int ID_NUM_SLOTS   = 14;  // populated slot positions 0..13
    localparam int ID_SYNC_STAGES = 2;   // flops before edge detection
endpackage

// File: rtl/id_edge_sync.sv
`timescale 1ns/1ps
// Brings the asynchronous identification clock into the system clock domain
// and emits a one-cycle pulse for every low-to-high transition.
// Assumes the identification clock stays at each level for several system
// clocks. All flops reset to 1, so a level already high at reset release
// produces no pulse.
module id_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic id_clk_async,
    output logic rise_pulse
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] the previous one
    logic [STAGES:0] chain;

    // Shift the async level through the synchronizer plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-1:0], id_clk_async};
        end
    end

    // A rise is the synchronized level high while the previous level was low
    assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];

    // R2: one synchronized rise gives exactly one pulse
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/id_edge_counter.sv
`timescale 1ns/1ps
// Counts identification-clock rises since reset release and saturates at
// MAX, which lies past the last possible window. After saturation the count
// never wraps back into an earlier window.
module id_edge_counter #(
    parameter int MAX   = 112,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             saturated
);
    // Flag the ceiling so the serializer can tell the schedule is over
    assign saturated = (count == CNT_W'(MAX));

    // Advance once per rise until the ceiling is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (step && !saturated) begin
            count <= count + 1'b1;
        end
    end

    // R5: the count never passes its ceiling
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX));

    // R2: the count moves by at most one per system clock and never backward
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/id_bit_serializer.sv
`timescale 1ns/1ps
// Holds the slot number and type code captured during reset. Decides whether
// the current count falls inside this slot's window and, if so, which code
// bit to present, most significant bit first. Drives a registered pull-low
// request: a 0 bit sinks the wire, a 1 bit or no window releases it.
module id_bit_serializer #(
    parameter int CODE_W    = 8,
    parameter int SLOT_W    = 4,
    parameter int NUM_SLOTS = 14,
    parameter int CNT_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic [CODE_W-1:0] type_code,
    input  logic [CNT_W-1:0]  count,
    input  logic              saturated,
    output logic              pull
);
    localparam int BIT_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam int WIDE   = (CNT_W > SLOT_W + BIT_W) ? CNT_W : SLOT_W + BIT_W;
    localparam int CALC_W = WIDE + 1;

    logic [SLOT_W-1:0] slot_q;
    logic [CODE_W-1:0] code_q;
    logic [CALC_W-1:0] cnt_ext;
    logic [CALC_W-1:0] win_start;
    logic [CALC_W-1:0] win_stop;
    logic [BIT_W-1:0]  offset;
    logic [BIT_W-1:0]  sel;
    logic              slot_ok;
    logic              in_win;
    logic              pull_next;

    // Capture the wired slot and type code while reset holds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= slot_id;
            code_q <= type_code;
        end
    end

    // Locate the window and the code bit for the current count
    always_comb begin
        cnt_ext   = CALC_W'(count);
        win_start = CALC_W'(slot_q) * CALC_W'(CODE_W);
        win_stop  = win_start + CALC_W'(CODE_W);
        offset    = BIT_W'(cnt_ext - win_start);
        sel       = BIT_W'(CODE_W - 1) - offset;
        slot_ok   = (int'(slot_q) < NUM_SLOTS);
        in_win    = slot_ok && (cnt_ext >= win_start) && (cnt_ext < win_stop);
        pull_next = in_win && !code_q[sel];
    end

    // Register the pull request so the wire driver sees a clean level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull <= 1'b0;
        end else begin
            pull <= pull_next;
        end
    end

    // R1: a cycle in reset always leaves the wire released
    p_release_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !pull);

    // R6: captured slot and code hold while reset stays released
    p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(slot_q) && $stable(code_q));

    // R7: an unpopulated slot position never sinks the wire
    p_bad_slot_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(slot_q) >= NUM_SLOTS) |-> !pull);

    // R5: once the count has saturated the wire stays released
    p_silent_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (saturated && $past(saturated)) |-> !pull);
endmodule

// File: rtl/slot_type_announcer.sv
`timescale 1ns/1ps
// Per-module type announcer for the shared identification wire.
// Counts synchronized identification-clock rises from reset release. Inside
// the window of eight counts that starts at eight times the wired slot
// number, it shifts out the type code MSB first on an open-drain request.
// Assumes the console holds each identification-clock level for several
// system clocks.
module slot_type_announcer
    import slot_id_pkg::*;
#(
    parameter int CODE_W      = ID_CODE_W,
    parameter int SLOT_W      = ID_SLOT_W,
    parameter int NUM_SLOTS   = ID_NUM_SLOTS,
    parameter int SYNC_STAGES = ID_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_clk,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic [CODE_W-1:0] type_code,
    output logic              id_pull
);
    localparam int CNT_MAX = NUM_SLOTS * CODE_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             rise;
    logic [CNT_W-1:0] count;
    logic             saturated;

    id_edge_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .id_clk_async (id_clk),
        .rise_pulse   (rise)
    );

    id_edge_counter #(
        .MAX   (CNT_MAX),
        .CNT_W (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (rise),
        .count     (count),
        .saturated (saturated)
    );

    id_bit_serializer #(
        .CODE_W    (CODE_W),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_id   (slot_id),
        .type_code (type_code),
        .count     (count),
        .saturated (saturated),
        .pull      (id_pull)
    );
endmodule

// File: tb/test_slot_type_announcer.sv
`timescale 1ns/1ps
// Directed bench for the slot-scheduled type announcer.
module test_slot_type_announcer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_clk = 1'b0;
    logic [3:0] slot_id = 4'd0;
    logic [7:0] type_code = 8'h00;
    logic       id_pull;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    slot_type_announcer i_slot_type_announcer (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_clk    (id_clk),
        .slot_id   (slot_id),
        .type_code (type_code),
        .id_pull   (id_pull)
    );

    // Expected pull request for a given count, slot and code
    function automatic bit exp_pull(int c, int s, logic [7:0] code);
        if (s < 14 && c >= 8 * s && c < 8 * s + 8) return !code[7 - (c - 8 * s)];
        return 1'b0;
    endfunction

    task automatic check(bit actual, bit expected, string req);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset with new wiring; R1 checked while reset is held
    task automatic do_reset(logic [3:0] s, logic [7:0] code, bit idc);
        @(negedge clk);
        rst_n = 1'b0; id_clk = idc; slot_id = s; type_code = code;
        cycles(4);
        check(id_pull, 1'b0, "R1");
        rst_n = 1'b1;
        cycles(2);
    endtask

    task automatic id_period();
        id_clk = 1'b1; cycles(5);
        id_clk = 1'b0; cycles(5);
    endtask

    // R3/R4/R5: walk a slot through its window and beyond
    task automatic t_scan(int s, logic [7:0] code, int extra);
        do_reset(4'(s), code, 1'b0);
        for (int c = 0; c < 8 * s + 8 + extra; c++) begin
            if (c < 8 * s)          check(id_pull, exp_pull(c, s, code), "R3");
            else if (c < 8 * s + 8) check(id_pull, exp_pull(c, s, code), "R4");
            else                    check(id_pull, exp_pull(c, s, code), "R5");
            id_period();
        end
    endtask

    // R2: id_clk high across reset release is not an edge; falls do not count
    task automatic t_high_at_release();
        do_reset(4'd0, 8'b0101_0011, 1'b1);
        cycles(8);
        check(id_pull, 1'b1, "R2");
        id_clk = 1'b0; cycles(8);
        check(id_pull, 1'b1, "R2");
        id_clk = 1'b1; cycles(5);
        check(id_pull, 1'b0, "R2");
        id_clk = 1'b0; cycles(5);
    endtask

    // R9: exact latency from id_clk rise to wire change
    task automatic t_latency();
        do_reset(4'd0, 8'b1000_0000, 1'b0);
        check(id_pull, 1'b0, "R9");
        id_clk = 1'b1;
        cycles(3);
        check(id_pull, 1'b0, "R9");
        cycles(1);
        check(id_pull, 1'b1, "R9");
        cycles(1);
        id_clk = 1'b0; cycles(5);
    endtask

    // R6: changing wiring after release has no effect
    task automatic t_capture();
        do_reset(4'd2, 8'b0011_0110, 1'b0);
        slot_id = 4'd0; type_code = 8'h00;
        for (int c = 0; c < 28; c++) begin
            check(id_pull, exp_pull(c, 2, 8'b0011_0110), "R6");
            id_period();
        end
    endtask

    // R7: out-of-range slots never drive
    task automatic t_bad_slot(logic [3:0] s);
        do_reset(s, 8'h00, 1'b0);
        for (int c = 0; c < 130; c++) begin
            check(id_pull, 1'b0, "R7");
            id_period();
        end
    endtask

    // R8: reset mid-window restarts with new wiring
    task automatic t_rereset();
        do_reset(4'd1, 8'h00, 1'b0);
        repeat (10) id_period();
        check(id_pull, 1'b1, "R8");
        @(negedge clk);
        rst_n = 1'b0; slot_id = 4'd0; type_code = 8'b0111_1111;
        cycles(2);
        check(id_pull, 1'b0, "R8");
        rst_n = 1'b1;
        cycles(2);
        check(id_pull, 1'b1, "R8");
        id_period();
        check(id_pull, 1'b0, "R8");
    endtask

    initial begin
        t_scan(0, 8'b0101_0011, 6);
        t_scan(1, 8'b1100_1010, 6);
        t_scan(5, 8'b0000_0001, 4);
        t_scan(13, 8'b1011_0100, 300);
        t_high_at_release();
        t_latency();
        t_capture();
        t_bad_slot(4'd14);
        t_bad_slot(4'd15);
        t_rereset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule